// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit gathers single-cycle event pulses from an I2C controller's bit engine and FIFO logic into one bit-mapped status register. Software clears pending events by writing ones. An enable register decides which pending events drive the interrupt line. A separate wakeup-enable register decides which pending events drive a wakeup line, so the controller can rouse a sleeping system. The bus-busy position shows the live bus state and is not stored.

Older drivers do not scan the status bits. For them, a vector register reports a small code for the most urgent enabled event. Reading the vector through the read strobe clears exactly that event. Register selection, write data and read data all go through one simple port. Read data is combinational. Writes and read side effects take effect at the next rising clock edge.

Top module: `irq_event_hub`

## Requirements
- R1: After synchronous reset, the status, enable and wakeup-enable registers read 0 (the status busy bit still shows the live bus state). The vector reads 0, and irq and wake are low.
- R2: Status bit positions are fixed: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, address-zero 8, addressed-as-slave 9, transmit underflow 10, receive overrun 11, bus busy 12, receive drain 13, transmit drain 14. A pulse on ev_pulse[k] sets status bit k at the next edge. Pulses on any other position, including 12, are ignored, and positions 5 to 7 and 15 read 0.
- R3: A write to the status register clears each bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: Status bit 12 follows bus_busy in the same cycle, and writes do not affect it.
- R5: An event pulse in the same cycle as a clear of its bit, whether by status write or by vector read, leaves the bit set.
- R6: The enable register stores only bits 0 to 4, 13 and 14. Its other bits read 0.
- R7: irq is high exactly when some status bit is set together with its enable bit. It follows a register change without further delay.
- R8: The wakeup-enable register stores bits 0, 1, 2, 3, 5, 6, 8, 9, 13 and 14. The sources that drive wake are: bit 0 arbitration lost, bit 1 no-acknowledge, bit 2 access ready, bit 3 data ready (receive ready or transmit ready), bit 9 addressed-as-slave, bit 13 receive drain and bit 14 transmit drain. Bits 5, 6 and 8 are stored but never raise wake.
- R9: The vector reads the code of the highest-priority event that is both pending and enabled. Codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready and 0 for none. A lower code has higher priority.
- R10: A vector read with rd_en high clears only the status bit it reported, at the next edge.
- R11: The register select encoding is 0 status, 1 enable, 2 wakeup-enable and 3 vector. rd_data shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 16 | Event pulses, one per status position |
| bus_busy | input | 1 | Live bus-busy level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (gives the vector read its clearing side effect) |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Selected register contents |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
Each event pulse, status write, enable or wakeup-enable write, and clearing vector read lands at the first rising edge after it is driven. Its results (status contents, irq, wake and vector code) are therefore due one cycle after the stimulus. The bench drives each stimulus on a falling edge and reads the results at the following falling edge. rd_data and the live busy bit are combinational, so the bench samples them a nanosecond after changing the select or bus_busy, with no edge in between. For a clearing vector read, the bench takes the code in the cycle the strobe is high and the cleared status one cycle later.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
    localparam int REG_W  = 16;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_WAKE   = 2'd2,
        SEL_VECTOR = 2'd3
    } reg_sel_e;

    // status positions
    localparam int B_ARB     = 0;
    localparam int B_NOACK   = 1;
    localparam int B_ACCRDY  = 2;
    localparam int B_RXRDY   = 3;
    localparam int B_TXRDY   = 4;
    localparam int B_ADDR0   = 8;
    localparam int B_ADDRSLV = 9;
    localparam int B_TXUND   = 10;
    localparam int B_RXOVR   = 11;
    localparam int B_BUSY    = 12;
    localparam int B_RXDRAIN = 13;
    localparam int B_TXDRAIN = 14;

    // wakeup-only positions
    localparam int W_DATARDY = 3;
    localparam int W_GCALL   = 5;
    localparam int W_STARTC  = 6;
    localparam int W_BFREE   = 8;

    localparam logic [REG_W-1:0] ONE = REG_W'(1);

    localparam logic [REG_W-1:0] EVT_MASK =
        (ONE << B_ARB) | (ONE << B_NOACK) | (ONE << B_ACCRDY) | (ONE << B_RXRDY) |
        (ONE << B_TXRDY) | (ONE << B_ADDR0) | (ONE << B_ADDRSLV) | (ONE << B_TXUND) |
        (ONE << B_RXOVR) | (ONE << B_RXDRAIN) | (ONE << B_TXDRAIN);

    localparam logic [REG_W-1:0] ENA_MASK =
        (ONE << B_ARB) | (ONE << B_NOACK) | (ONE << B_ACCRDY) | (ONE << B_RXRDY) |
        (ONE << B_TXRDY) | (ONE << B_RXDRAIN) | (ONE << B_TXDRAIN);

    localparam logic [REG_W-1:0] WAKE_MASK =
        (ONE << B_ARB) | (ONE << B_NOACK) | (ONE << B_ACCRDY) | (ONE << W_DATARDY) |
        (ONE << W_GCALL) | (ONE << W_STARTC) | (ONE << W_BFREE) | (ONE << B_ADDRSLV) |
        (ONE << B_RXDRAIN) | (ONE << B_TXDRAIN);

    // vector sources occupy status bits 0..VEC_N-1, code = position + 1
    localparam int VEC_N = 5;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [REG_W-1:0]  clr;
    } vec_t;

    function automatic vec_t vec_pick(input logic [REG_W-1:0] pend);
        vec_t r;
        r = '0;
        for (int i = VEC_N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                r.code   = CODE_W'(i + 1);
                r.clr    = '0;
                r.clr[i] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] wake_sources(input logic [REG_W-1:0] st);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_ARB]     = st[B_ARB];
        w[B_NOACK]   = st[B_NOACK];
        w[B_ACCRDY]  = st[B_ACCRDY];
        w[W_DATARDY] = st[B_RXRDY] | st[B_TXRDY];
        w[B_ADDRSLV] = st[B_ADDRSLV];
        w[B_RXDRAIN] = st[B_RXDRAIN];
        w[B_TXDRAIN] = st[B_TXDRAIN];
        return w;
    endfunction
endpackage

// File: rtl/irq_hub_status.sv
`timescale 1ns/1ps
module irq_hub_status #(
    parameter int               W        = irq_hub_pkg::REG_W,
    parameter logic [W-1:0]     MASK     = irq_hub_pkg::EVT_MASK,
    parameter int               BUSY_POS = irq_hub_pkg::B_BUSY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] clr,
    input  logic         busy,
    output logic [W-1:0] stat
);
    logic unused_bits;
    assign unused_bits = ^(ev & ~MASK) ^ ^(clr & ~MASK);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (MASK[b]) begin : g_ff
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= ev[b] | (q & ~clr[b]);
            end
            assign stat[b] = q;
        end else if (b == BUSY_POS) begin : g_live
            assign stat[b] = busy;
        end else begin : g_zero
            assign stat[b] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_hub_maskreg.sv
`timescale 1ns/1ps
module irq_hub_maskreg #(
    parameter int           W    = irq_hub_pkg::REG_W,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d & MASK;
    end
endmodule

// File: rtl/irq_hub_vector.sv
`timescale 1ns/1ps
module irq_hub_vector
    import irq_hub_pkg::*;
(
    input  logic [REG_W-1:0]  pend,
    output logic [CODE_W-1:0] code,
    output logic [REG_W-1:0]  clr_onehot
);
    vec_t pick;
    assign pick       = vec_pick(pend);
    assign code       = pick.code;
    assign clr_onehot = pick.clr;
endmodule

// File: rtl/irq_event_hub.sv
`timescale 1ns/1ps
module irq_event_hub
    import irq_hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ev_pulse,
    input  logic             bus_busy,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             wake
);
    reg_sel_e wsel, rsel;
    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    logic [REG_W-1:0]  stat_vec, enable_q, wake_q;
    logic [REG_W-1:0]  w1c, vec_clr, vec_onehot, clr_all;
    logic [CODE_W-1:0] vec_code;

    assign w1c     = (wr_en && wsel == SEL_STATUS) ? wr_data : '0;
    assign vec_clr = (rd_en && rsel == SEL_VECTOR) ? vec_onehot : '0;
    assign clr_all = w1c | vec_clr;

    irq_hub_status #(.W(REG_W), .MASK(EVT_MASK), .BUSY_POS(B_BUSY)) u_status (
        .clk (clk), .rst (rst), .ev (ev_pulse), .clr (clr_all),
        .busy(bus_busy), .stat(stat_vec)
    );

    irq_hub_maskreg #(.W(REG_W), .MASK(ENA_MASK)) u_enable (
        .clk(clk), .rst(rst), .load(wr_en && wsel == SEL_ENABLE),
        .d(wr_data), .q(enable_q)
    );

    irq_hub_maskreg #(.W(REG_W), .MASK(WAKE_MASK)) u_wake (
        .clk(clk), .rst(rst), .load(wr_en && wsel == SEL_WAKE),
        .d(wr_data), .q(wake_q)
    );

    irq_hub_vector u_vector (
        .pend(stat_vec & enable_q), .code(vec_code), .clr_onehot(vec_onehot)
    );

    assign irq  = |(stat_vec & enable_q);
    assign wake = |(wake_sources(stat_vec) & wake_q);

    always_comb begin
        unique case (rsel)
            SEL_STATUS: rd_data = stat_vec;
            SEL_ENABLE: rd_data = enable_q;
            SEL_WAKE:   rd_data = wake_q;
            SEL_VECTOR: rd_data = REG_W'(vec_code);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_event_hub_chk.sv
`timescale 1ns/1ps
module irq_event_hub_chk
    import irq_hub_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] ev_pulse,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic             rd_en,
    input logic [1:0]       rd_sel,
    input logic             irq,
    input logic             wake,
    input logic [REG_W-1:0] stat_vec,
    input logic [REG_W-1:0] vec_onehot
);
    // R3: written ones clear their bits unless an event arrives
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=>
            ((stat_vec & $past(wr_data) & ~$past(ev_pulse) & EVT_MASK) == '0));

    // R2 / R5: an event always lands, regardless of clears
    a_r5_event_sticks: assert property (@(posedge clk) disable iff (rst)
        (|(ev_pulse & EVT_MASK)) |=>
            ((stat_vec & $past(ev_pulse & EVT_MASK)) == $past(ev_pulse & EVT_MASK)));

    // R7: irq can only rise after an event or an enable write
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(|ev_pulse) || $past(wr_en && wr_sel == 2'd1)));

    // R8: wake can only rise after an event or a wakeup-enable write
    a_r8_wake_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> ($past(|ev_pulse) || $past(wr_en && wr_sel == 2'd2)));

    // R9: at most one event is named by the vector
    a_r9_vec_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vec_onehot));

    // R10: the reported event is cleared by a vector read
    a_r10_vec_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd3 && (vec_onehot & ev_pulse) == '0 && vec_onehot != '0
         && !(wr_en && wr_sel == 2'd0)) |=>
            ((stat_vec & $past(vec_onehot)) == '0));
endmodule

bind irq_event_hub irq_event_hub_chk u_chk (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .irq(irq), .wake(wake),
    .stat_vec(stat_vec), .vec_onehot(vec_onehot)
);

// File: tb/irq_event_hub_test.sv
`timescale 1ns/1ps
module irq_event_hub_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ev_pulse = '0;
    logic        bus_busy = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        irq, wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_event_hub uut (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .bus_busy(bus_busy),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .wake(wake)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] m);
        ev_pulse = m;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    task automatic wreg(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [15:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic vread(output logic [15:0] v);
        rd_sel = 2'd3; rd_en = 1'b1;
        #1;
        v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        peek(2'd0, v); chk("R1 status", v, 16'h0000);
        peek(2'd1, v); chk("R1 enable", v, 16'h0000);
        peek(2'd2, v); chk("R1 wake-enable", v, 16'h0000);
        peek(2'd3, v); chk("R1 vector", v, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);
        chk("R1 wake", {15'b0, wake}, 16'h0000);
    endtask

    task automatic t_positions;
        logic [15:0] v;
        pulse(16'hFFFF);
        peek(2'd0, v); chk("R2 all positions", v, 16'h6F1F);
        wreg(2'd0, 16'hFFFF);
        peek(2'd0, v); chk("R3 clear all", v, 16'h0000);
        pulse(16'h0003);
        wreg(2'd0, 16'h0001);
        peek(2'd0, v); chk("R3 selective clear", v, 16'h0002);
        wreg(2'd0, 16'h0000);
        peek(2'd0, v); chk("R3 zero write keeps", v, 16'h0002);
        wreg(2'd0, 16'hFFFF);
    endtask

    task automatic t_busy;
        logic [15:0] v;
        bus_busy = 1'b1;
        peek(2'd0, v); chk("R4 busy live", v, 16'h1000);
        wreg(2'd0, 16'h1000);
        peek(2'd0, v); chk("R4 busy write ignored", v, 16'h1000);
        bus_busy = 1'b0;
        peek(2'd0, v); chk("R4 busy drop", v, 16'h0000);
    endtask

    task automatic t_race;
        logic [15:0] v;
        pulse(16'h0002);
        ev_pulse = 16'h0002;
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0002;
        @(negedge clk);
        ev_pulse = '0; wr_en = 1'b0; wr_data = '0;
        peek(2'd0, v); chk("R5 event beats clear", v, 16'h0002);
        wreg(2'd0, 16'hFFFF);
    endtask

    task automatic t_enable;
        logic [15:0] v;
        wreg(2'd1, 16'hFFFF);
        peek(2'd1, v); chk("R6 enable storage", v, 16'h601F);
        chk("R7 idle irq", {15'b0, irq}, 16'h0000);
        pulse(16'h0400);
        chk("R7 underflow not enableable", {15'b0, irq}, 16'h0000);
        pulse(16'h2000);
        chk("R7 drain raises irq", {15'b0, irq}, 16'h0001);
        wreg(2'd0, 16'h2400);
        chk("R7 cleared irq", {15'b0, irq}, 16'h0000);
        wreg(2'd1, 16'h0000);
        pulse(16'h0001);
        chk("R7 masked pending", {15'b0, irq}, 16'h0000);
        wreg(2'd1, 16'h0001);
        chk("R7 enable late", {15'b0, irq}, 16'h0001);
        wreg(2'd0, 16'hFFFF);
        wreg(2'd1, 16'h0000);
    endtask

    task automatic t_wake;
        logic [15:0] v;
        wreg(2'd2, 16'hFFFF);
        peek(2'd2, v); chk("R8 wake storage", v, 16'h636F);
        wreg(2'd2, 16'h0160);
        pulse(16'h7F1F);
        peek(2'd0, v); chk("R2 busy position pulse ignored", v, 16'h6F1F);
        chk("R8 sourceless bits no wake", {15'b0, wake}, 16'h0000);
        wreg(2'd0, 16'hFFFF);
        wreg(2'd2, 16'h0008);
        pulse(16'h0010);
        chk("R8 data-ready from transmit", {15'b0, wake}, 16'h0001);
        wreg(2'd0, 16'hFFFF);
        chk("R8 wake cleared", {15'b0, wake}, 16'h0000);
        pulse(16'h0008);
        chk("R8 data-ready from receive", {15'b0, wake}, 16'h0001);
        wreg(2'd0, 16'hFFFF);
        wreg(2'd2, 16'h0200);
        pulse(16'h0200);
        chk("R8 slave-addressed wake", {15'b0, wake}, 16'h0001);
        wreg(2'd0, 16'hFFFF);
        wreg(2'd2, 16'h0000);
    endtask

    task automatic t_vector;
        logic [15:0] v, s;
        wreg(2'd1, 16'h601F);
        pulse(16'h001F);
        for (int k = 1; k <= 5; k++) begin
            vread(v);
            chk($sformatf("R9 code step %0d", k), v, 16'(k));
            peek(2'd0, s);
            chk($sformatf("R10 cleared step %0d", k), s, 16'h001F & ~((16'h0002 << (k - 1)) - 16'h0001));
        end
        vread(v); chk("R9 none", v, 16'h0000);
        wreg(2'd1, 16'h0002);
        pulse(16'h0003);
        vread(v); chk("R9 masked priority", v, 16'h0002);
        peek(2'd0, s); chk("R10 only reported cleared", s, 16'h0001);
        peek(2'd3, v); chk("R11 vector peek no strobe", v, 16'h0000);
        wreg(2'd0, 16'hFFFF);
        wreg(2'd1, 16'h601F);
        pulse(16'h0001);
        ev_pulse = 16'h0001;
        vread(v);
        ev_pulse = '0;
        chk("R9 race code", v, 16'h0001);
        peek(2'd0, s); chk("R5 event beats vector clear", s, 16'h0001);
        wreg(2'd0, 16'hFFFF);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_positions;
        t_busy;
        t_race;
        t_enable;
        t_wake;
        t_vector;
        done = 1'b1;
        report;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report;
        end
    end
endmodule